// File: doc/BRIEF.md
# Multi-mode interval timer channel

This block is one 16-bit down-counting timer channel. The counting element is decremented by the block clock. An external gate input can pause counting, retrigger it or restart it. The single output pin follows one of six waveform programs: a level that rises at terminal count, a one-shot low pulse started by the gate, a periodic one-clock low pulse, a square wave, a one-clock strobe started by software, and a one-clock strobe started by the gate. The counting element can be binary or four BCD decades.

Software programs the channel over a byte-wide write stream. A byte marked as control selects the waveform program, the byte order used for the count and the number system. Bytes not marked as control carry the initial count. The write stream uses valid/ready. `wr_ready` is held high at all times, so a byte is taken on every clock edge where `wr_valid` is high and there is never back-pressure. The live count and a pending-load flag are brought out for an external read path.

Top module: `interval_timer`

## Requirements
- R1: A control byte is decoded as bits 7:6 channel select, bits 5:4 count byte order, bits 3:1 program, and bit 0 BCD enable. The byte is accepted only when the select equals the CHAN_SEL parameter (default 0) and the byte order field is non-zero. Any other control byte, including one with byte order 00, changes neither the program nor the output waveform. Program codes 110 and 111 act as 010 and 011.
- R2: Count byte order 01 writes the low byte and clears the high byte. Order 10 writes the high byte and clears the low byte. Order 11 takes the low byte first and then the high byte.
- R3: `null_count` goes high on the edge that completes a count write. It goes low on the edge that copies the count into the counting element. In program 1 and program 5 that copy happens only at the gate trigger.
- R4: Program 0 sets `out` low when the control byte is accepted and when a count write starts. The count loads one clock after the write completes. `out` then goes high after N further enabled clocks and stays high until the next control byte or count write.
- R5: In program 0 with byte order 11, the low byte stops counting and holds `out` low. The count stays frozen until the high byte arrives.
- R6: Program 1 starts with `out` high. On a clock that sees the gate rise, the count is loaded and `out` goes low for N clocks. Another gate rise reloads the count and extends the pulse.
- R7: Program 2 loads one clock after the count write. In every period of N clocks, `out` is low for exactly one clock, when the count has reached 1. The count then reloads.
- R8: Program 3 gives a period of N clocks with `out` high for (N+1)/2 clocks and low for the rest (N ≥ 2). It repeats without end.
- R9: Program 4 loads one clock after the count write. `out` goes low for one clock N clocks after the load and then stays high.
- R10: Program 5 loads on a clock that sees the gate rise. `out` goes low for one clock N clocks later.
- R11: In programs 0, 2, 3 and 4, a low gate freezes the count. In programs 2 and 3, a low gate also drives `out` high from the next clock. A gate rise then reloads the count.
- R12: An initial count of 0 acts as 65536 in binary and as 10000 in BCD. In BCD each 4-bit decade borrows from 0 to 9.
- R13: After reset, `out` is low, `count` is 0, `null_count` is low and `wr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block and counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | A byte is offered on the write stream |
| wr_ready | output | 1 | Always high; the write stream never stalls |
| wr_ctrl | input | 1 | The offered byte is a control byte |
| wr_data | input | BYTE_W | Write byte |
| gate | input | 1 | Gate level; its rising edge is detected on the clock |
| out | output | 1 | Timer output waveform |
| count | output | 2*BYTE_W | Live value of the counting element |
| null_count | output | 1 | A written count is still waiting to be loaded |

## Verification
A wrong reload value or a wrong decrement step appears on `count` on the very next clock. The sweeps compare that value on every cycle against a value computed from N. A phase error in the square wave or the rate pulse appears on `out` within one period of at most N clocks, and the bench checks every cycle of three full periods for each small N. A BCD borrow fault appears ten clocks after a decade rolls over. A missed gate freeze or a missed gate reload shifts every later output edge, so the checks after each gate event expose it at once.

// File: rtl/itm_pkg.sv
package itm_pkg;

  typedef enum logic [2:0] {
    M_TC       = 3'd0,
    M_ONESHOT  = 3'd1,
    M_RATE     = 3'd2,
    M_SQUARE   = 3'd3,
    M_SWSTROBE = 3'd4,
    M_HWSTROBE = 3'd5
  } itm_mode_e;

  localparam logic [1:0] ORD_NONE = 2'b00;
  localparam logic [1:0] ORD_LO   = 2'b01;
  localparam logic [1:0] ORD_HI   = 2'b10;
  localparam logic [1:0] ORD_BOTH = 2'b11;

  // codes 11x fold onto the periodic programs
  function automatic itm_mode_e itm_norm_mode(input logic [2:0] raw);
    if (raw[2:1] == 2'b11) return itm_mode_e'({1'b0, raw[1:0]});
    return itm_mode_e'(raw);
  endfunction

endpackage

// File: rtl/itm_decrement.sv
module itm_decrement #(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CNT_W-1:0] x,
  input  logic             bcd,
  output logic [CNT_W-1:0] y
);
  localparam int unsigned DIGITS = CNT_W / 4;

  logic [DIGITS-1:0] borrow;
  logic [CNT_W-1:0]  y_bcd;

  assign borrow[0] = 1'b1;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [3:0] dig;
    assign dig = x[4*g +: 4];
    assign y_bcd[4*g +: 4] = !borrow[g] ? dig : ((dig == 4'd0) ? 4'd9 : dig - 4'd1);
    if (g < DIGITS - 1) begin : g_chain
      assign borrow[g+1] = borrow[g] & (dig == 4'd0);
    end
  end

  assign y = bcd ? y_bcd : (x - 1'b1);

endmodule

// File: rtl/itm_wr_port.sv
module itm_wr_port
  import itm_pkg::*;
#(
  parameter int unsigned BYTE_W   = 8,
  parameter logic [1:0]  CHAN_SEL = 2'd0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_fire,
  input  logic                  wr_ctrl,
  input  logic [BYTE_W-1:0]     wr_data,
  output itm_mode_e             mode_q,
  output logic                  bcd_q,
  output logic [2*BYTE_W-1:0]   cr_q,
  output logic                  cfg_wr,
  output itm_mode_e             cfg_mode,
  output logic                  ld_req,
  output logic                  halt
);
  localparam int unsigned CNT_W = 2 * BYTE_W;

  logic [1:0] ord_q;
  logic       lo_pend_q;
  logic       cnt_fire;

  assign cfg_wr   = wr_fire && wr_ctrl && (wr_data[7:6] == CHAN_SEL) && (wr_data[5:4] != ORD_NONE);
  assign cfg_mode = itm_norm_mode(wr_data[3:1]);
  assign cnt_fire = wr_fire && !wr_ctrl;
  assign ld_req   = cnt_fire && ((ord_q != ORD_BOTH) || lo_pend_q);
  assign halt     = cnt_fire && (ord_q == ORD_BOTH) && !lo_pend_q && (mode_q == M_TC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= M_TC;
      bcd_q     <= 1'b0;
      ord_q     <= ORD_BOTH;
      lo_pend_q <= 1'b0;
      cr_q      <= '0;
    end else if (cfg_wr) begin
      mode_q    <= cfg_mode;
      bcd_q     <= wr_data[0];
      ord_q     <= wr_data[5:4];
      lo_pend_q <= 1'b0;
    end else if (cnt_fire) begin
      unique case (ord_q)
        ORD_LO: cr_q <= {{(CNT_W-BYTE_W){1'b0}}, wr_data};
        ORD_HI: cr_q <= {wr_data, {BYTE_W{1'b0}}};
        default: begin
          if (!lo_pend_q) begin
            cr_q[BYTE_W-1:0] <= wr_data;
            lo_pend_q        <= 1'b1;
          end else begin
            cr_q[CNT_W-1:BYTE_W] <= wr_data;
            lo_pend_q            <= 1'b0;
          end
        end
      endcase
    end
  end

  AST_FOREIGN_SEL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_ctrl && wr_data[7:6] != CHAN_SEL) |=> ($stable(mode_q) && $stable(ord_q))); // R1
  AST_ORDER_NONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_ctrl && wr_data[5:4] == ORD_NONE) |=> ($stable(mode_q) && $stable(bcd_q))); // R1

endmodule

// File: rtl/itm_core.sv
module itm_core
  import itm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  itm_mode_e        mode_q,
  input  logic             bcd,
  input  logic [CNT_W-1:0] cr,
  input  logic             cfg_wr,
  input  itm_mode_e        cfg_mode,
  input  logic             ld_req,
  input  logic             halt,
  input  logic             gate,
  output logic             out_q,
  output logic [CNT_W-1:0] ce_q,
  output logic             null_q
);
  logic             run_q, pend_q, armed_q, have_q, gate_q;
  logic [CNT_W-1:0] dec1, dec2;
  logic             gate_rise, cnt_en, is_periodic, is_strobe, is_hwtrig, ce_is1, ce_is2;

  itm_decrement #(.CNT_W(CNT_W)) u_dec1 (.x(ce_q), .bcd(bcd), .y(dec1));
  itm_decrement #(.CNT_W(CNT_W)) u_dec2 (.x(dec1), .bcd(bcd), .y(dec2));

  assign gate_rise   = gate && !gate_q;
  assign is_periodic = (mode_q == M_RATE) || (mode_q == M_SQUARE);
  assign is_strobe   = (mode_q == M_SWSTROBE) || (mode_q == M_HWSTROBE);
  assign is_hwtrig   = (mode_q == M_ONESHOT) || (mode_q == M_HWSTROBE);
  assign cnt_en      = is_hwtrig ? 1'b1 : gate;
  assign ce_is1      = (ce_q == CNT_W'(1));
  assign ce_is2      = (ce_q == CNT_W'(2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q    <= '0;
      out_q   <= 1'b0;
      run_q   <= 1'b0;
      pend_q  <= 1'b0;
      armed_q <= 1'b0;
      have_q  <= 1'b0;
      null_q  <= 1'b0;
      gate_q  <= 1'b1;
    end else begin
      gate_q <= gate;
      if (cfg_wr) begin
        run_q   <= 1'b0;
        pend_q  <= 1'b0;
        armed_q <= 1'b0;
        have_q  <= 1'b0;
        out_q   <= (cfg_mode != M_TC);
      end else begin
        if (is_strobe) out_q <= 1'b1;
        if (ld_req) begin
          null_q <= 1'b1;
          have_q <= 1'b1;
          unique case (mode_q)
            M_TC:                begin out_q <= 1'b0; run_q <= 1'b0; pend_q <= 1'b1; end
            M_SWSTROBE:          begin run_q <= 1'b0; pend_q <= 1'b1; end
            M_RATE, M_SQUARE:    if (!run_q) pend_q <= 1'b1;
            default:             ;
          endcase
        end else if (halt) begin
          out_q  <= 1'b0;
          run_q  <= 1'b0;
          pend_q <= 1'b0;
        end else if (pend_q) begin
          ce_q    <= cr;
          run_q   <= 1'b1;
          null_q  <= 1'b0;
          pend_q  <= 1'b0;
          armed_q <= 1'b1;
          if (is_periodic) out_q <= 1'b1;
        end else if (gate_rise && have_q && is_hwtrig) begin
          ce_q    <= cr;
          run_q   <= 1'b1;
          null_q  <= 1'b0;
          armed_q <= 1'b1;
          if (mode_q == M_ONESHOT) out_q <= 1'b0;
        end else if (gate_rise && run_q && is_periodic) begin
          ce_q   <= cr;
          out_q  <= 1'b1;
          null_q <= 1'b0;
        end else if (run_q && cnt_en) begin
          unique case (mode_q)
            M_TC: begin
              ce_q <= dec1;
              if (ce_is1) out_q <= 1'b1;
            end
            M_ONESHOT: begin
              ce_q <= dec1;
              if (ce_is1 && armed_q) begin
                out_q   <= 1'b1;
                armed_q <= 1'b0;
              end
            end
            M_RATE: begin
              if (ce_is1) begin
                ce_q   <= cr;
                out_q  <= 1'b1;
                null_q <= 1'b0;
              end else begin
                ce_q  <= dec1;
                out_q <= !ce_is2;
              end
            end
            M_SQUARE: begin
              if (ce_is2) begin
                ce_q   <= out_q ? {cr[CNT_W-1:1], 1'b0} : cr;
                out_q  <= !out_q;
                null_q <= 1'b0;
              end else begin
                ce_q <= ce_q[0] ? dec1 : dec2;
              end
            end
            default: begin
              ce_q <= dec1;
              if (ce_is1 && armed_q) begin
                out_q   <= 1'b0;
                armed_q <= 1'b0;
              end
            end
          endcase
        end
        if (is_periodic && !gate) out_q <= 1'b1;
      end
    end
  end

  AST_LOAD_TRANSFER: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !cfg_wr && !ld_req && !halt) |=> ((ce_q == $past(cr)) && !null_q)); // R3
  AST_NULL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && !cfg_wr) |=> null_q); // R3
  AST_TC_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_TC && out_q && !cfg_wr && !ld_req && !halt) |=> out_q); // R4
  AST_RATE_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RATE && !out_q && !cfg_wr) |=> out_q); // R7
  AST_STROBE_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (is_strobe && !out_q && !cfg_wr) |=> out_q); // R9
  AST_GATE_FORCES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (is_periodic && !gate && !cfg_wr) |=> out_q); // R11
  AST_GATE_FREEZES_TC: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_TC && !gate && !cfg_wr && !ld_req && !halt && !pend_q) |=> $stable(ce_q)); // R11

endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itm_pkg::*;
#(
  parameter int unsigned BYTE_W   = 8,
  parameter logic [1:0]  CHAN_SEL = 2'd0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic                wr_ctrl,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic                gate,
  output logic                out,
  output logic [2*BYTE_W-1:0] count,
  output logic                null_count
);
  localparam int unsigned CNT_W = 2 * BYTE_W;

  itm_mode_e        mode_q, cfg_mode;
  logic             bcd_q, cfg_wr, ld_req, halt;
  logic [CNT_W-1:0] cr_q;

  assign wr_ready = 1'b1;

  itm_wr_port #(.BYTE_W(BYTE_W), .CHAN_SEL(CHAN_SEL)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_valid && wr_ready), .wr_ctrl(wr_ctrl),
    .wr_data(wr_data), .mode_q(mode_q), .bcd_q(bcd_q), .cr_q(cr_q),
    .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .ld_req(ld_req), .halt(halt)
  );

  itm_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .bcd(bcd_q), .cr(cr_q),
    .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .ld_req(ld_req), .halt(halt),
    .gate(gate), .out_q(out), .ce_q(count), .null_q(null_count)
  );

endmodule

// File: tb/test_interval_timer.sv
module test_interval_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ctrl = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        gate = 1'b1;
  logic        wr_ready, out, null_count;
  logic [15:0] count;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  interval_timer i_interval_timer (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_ctrl(wr_ctrl), .wr_data(wr_data), .gate(gate), .out(out),
    .count(count), .null_count(null_count)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic c, input logic [7:0] d);
    wr_valid = 1'b1; wr_ctrl = c; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0; wr_ctrl = 1'b0; wr_data = 8'h00;
  endtask

  task automatic cfg(input logic [2:0] m, input logic [1:0] f, input logic b);
    wr(1'b1, {2'b00, f, m, b});
  endtask

  task automatic trigger();
    gate = 1'b0; step();
    gate = 1'b1; step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    check("R13 out", out, 0);
    check("R13 count", count, 0);
    check("R13 null", null_count, 0);
    check("R13 ready", wr_ready, 1);

    // R4 program 0 basic terminal count
    cfg(3'd0, 2'b11, 1'b0);
    check("R4 out after cfg", out, 0);
    wr(1'b0, 8'd5);
    wr(1'b0, 8'd0);
    check("R3 null set", null_count, 1);
    step();
    check("R3 null cleared", null_count, 0);
    check("R4 load", count, 5);
    for (int k = 1; k <= 7; k++) begin
      step();
      check("R4 out", out, (k >= 5) ? 1 : 0);
      check("R4 count", count, (5 - k) & 16'hFFFF);
    end
    wr(1'b0, 8'd2);
    check("R4 rewrite low", out, 0);
    wr(1'b0, 8'd0);
    step(); step(); step();
    check("R4 high again", out, 1);

    // R5 partial write halts program 0
    cfg(3'd0, 2'b11, 1'b0);
    wr(1'b0, 8'h10); wr(1'b0, 8'h00);
    step(); step(); step(); step();
    check("R5 running", count, 16'h0D);
    wr(1'b0, 8'h40);
    for (int k = 0; k < 4; k++) begin
      check("R5 frozen", count, 16'h0D);
      check("R5 out low", out, 0);
      step();
    end
    wr(1'b0, 8'h00);
    step();
    check("R5 new load", count, 16'h40);

    // R11 gate freezes program 0
    cfg(3'd0, 2'b01, 1'b0);
    wr(1'b0, 8'd6);
    step(); step(); step();
    check("R11 before gate", count, 4);
    gate = 1'b0;
    for (int k = 0; k < 5; k++) begin
      step();
      check("R11 frozen", count, 4);
    end
    gate = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      step();
      check("R11 resume count", count, 4 - k);
      check("R11 resume out", out, (k == 4) ? 1 : 0);
    end

    // R2 byte orders
    cfg(3'd0, 2'b10, 1'b0); wr(1'b0, 8'h01); step();
    check("R2 high only", count, 16'h0100);
    cfg(3'd0, 2'b01, 1'b0); wr(1'b0, 8'h34); step();
    check("R2 low only", count, 16'h0034);
    cfg(3'd0, 2'b11, 1'b0); wr(1'b0, 8'h34); wr(1'b0, 8'h12); step();
    check("R2 both", count, 16'h1234);

    // R7 program 2 sweep
    for (int n = 2; n <= 7; n++) begin
      cfg(3'd2, 2'b01, 1'b0);
      wr(1'b0, 8'(n));
      for (int k = 0; k < 3 * n; k++) begin
        step();
        check("R7 out", out, ((k % n) == n - 1) ? 0 : 1);
        check("R7 count", count, n - (k % n));
      end
    end

    // R1 alias code 110 and ignored control bytes
    cfg(3'b110, 2'b01, 1'b0);
    wr(1'b0, 8'd4);
    for (int k = 0; k < 8; k++) begin
      step();
      check("R1 alias", out, ((k % 4) == 3) ? 0 : 1);
    end
    cfg(3'd2, 2'b01, 1'b0);
    wr(1'b0, 8'd5);
    for (int k = 0; k < 15; k++) begin
      if (k == 3)      wr(1'b1, 8'h50);
      else if (k == 7) wr(1'b1, 8'h00);
      else if (k == 9) wr(1'b1, 8'hD8);
      else             step();
      check("R1 ignored ctrl", out, ((k % 5) == 4) ? 0 : 1);
    end

    // R8 program 3 sweep
    for (int n = 2; n <= 7; n++) begin
      cfg(3'd3, 2'b01, 1'b0);
      wr(1'b0, 8'(n));
      for (int k = 0; k < 3 * n; k++) begin
        step();
        check("R8 out", out, ((k % n) < (n + 1) / 2) ? 1 : 0);
      end
    end
    cfg(3'd3, 2'b01, 1'b1);
    wr(1'b0, 8'h11);
    for (int k = 0; k < 33; k++) begin
      step();
      check("R8 bcd out", out, ((k % 11) < 6) ? 1 : 0);
    end

    // R11 gate in program 2
    cfg(3'd2, 2'b01, 1'b0);
    wr(1'b0, 8'd4);
    step(); step(); step();
    check("R11 m2 count", count, 2);
    gate = 1'b0;
    step();
    check("R11 forced high", out, 1);
    check("R11 m2 frozen", count, 2);
    step();
    check("R11 still high", out, 1);
    gate = 1'b1;
    step();
    check("R11 reload", count, 4);
    for (int k = 1; k <= 4; k++) begin
      step();
      check("R11 after reload", out, (k == 3) ? 0 : 1);
    end

    // R9 program 4
    for (int n = 3; n <= 5; n++) begin
      cfg(3'd4, 2'b01, 1'b0);
      check("R9 initial", out, 1);
      wr(1'b0, 8'(n));
      for (int k = 0; k <= n + 3; k++) begin
        step();
        check("R9 strobe", out, (k == n) ? 0 : 1);
      end
    end

    // R6 program 1
    cfg(3'd1, 2'b01, 1'b0);
    wr(1'b0, 8'd4);
    step(); step();
    check("R6 idle high", out, 1);
    check("R3 waits for trigger", null_count, 1);
    trigger();
    check("R3 trigger clears", null_count, 0);
    check("R6 trigger load", count, 4);
    for (int k = 0; k <= 5; k++) begin
      if (k > 0) step();
      check("R6 pulse", out, (k < 4) ? 0 : 1);
    end
    trigger();
    check("R6 second pulse", out, 0);
    gate = 1'b0; step();
    check("R6 mid pulse", count, 3);
    gate = 1'b1; step();
    check("R6 retrigger load", count, 4);
    for (int k = 0; k <= 4; k++) begin
      if (k > 0) step();
      check("R6 retrigger", out, (k < 4) ? 0 : 1);
    end

    // R10 program 5
    cfg(3'd5, 2'b01, 1'b0);
    wr(1'b0, 8'd3);
    step(); step();
    check("R10 idle", out, 1);
    trigger();
    for (int k = 0; k <= 5; k++) begin
      if (k > 0) step();
      check("R10 strobe", out, (k == 3) ? 0 : 1);
    end

    // R12 count of zero
    cfg(3'd2, 2'b01, 1'b0);
    wr(1'b0, 8'd0);
    for (int k = 0; k <= 65536; k++) begin
      step();
      if (k == 1) check("R12 bin wrap", count, 16'hFFFF);
      if (k == 65534 || k == 65536) check("R12 bin high", out, 1);
      if (k == 65535) check("R12 bin low", out, 0);
    end
    cfg(3'd2, 2'b01, 1'b1);
    wr(1'b0, 8'd0);
    for (int k = 0; k <= 10000; k++) begin
      step();
      if (k == 1)  check("R12 bcd wrap", count, 16'h9999);
      if (k == 11) check("R12 bcd borrow", count, 16'h9989);
      if (k == 9998 || k == 10000) check("R12 bcd high", out, 1);
      if (k == 9999) check("R12 bcd low", out, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule